// File: doc/BRIEF.md
# USB Host Controller Control Register

This block is the main control register of a USB host controller, together with the logic that runs the controller's functional state. It holds four things: the two-bit functional state, the interrupt-routing select, the two remote-wakeup bits, and the bulk-list enable. The driver reads and writes them through a simple 32-bit port. The hardware side supplies a resume-detected status, a software-reset strobe and a start-of-frame boundary pulse. Hardware reset is the active-low asynchronous `rst_ni`.

The block drives the following outputs:
- the start-of-frame enable;
- a root-hub reset request;
- a single-cycle remote-wakeup request;
- the interrupt-routing select;
- a bulk-list processing enable that changes only at frame boundaries.

Frame generation starts a fixed delay after the controller enters the Operational state. The delay is one millisecond, expressed as `CYC_PER_MS` clock cycles. Leaving Operational before the delay expires cancels the launch.

Register layout:
- bit 10: remote-wakeup enable
- bit 9: remote-wakeup connected
- bit 8: interrupt routing
- bits 7:6: functional state
- bit 5: bulk-list enable
- bits 31:11 and 4:0: reserved, read as zero

Top module: `hc_ctrl_reg`

## Requirements
- R1: While `rst_ni` is low and after it is released, `rdata_o` reads 0x0, the functional state is Reset (00) and every output other than `rh_reset_o` is low.
- R2: A write with `wr_en_i` high updates bits 10:5 on the following clock edge. Bits 7:6 encode the state as 00 Reset, 01 Resume, 10 Operational, 11 Suspend. Bits 31:11 and 4:0 always read zero.
- R3: `rh_reset_o` is high exactly while the functional state is Reset.
- R4: `sof_en_o` rises exactly `CYC_PER_MS` clock cycles after the state register enters Operational from any other state. Writing Operational while already in Operational does not restart the delay and does not drop the enable.
- R5: Leaving Operational clears `sof_en_o` on the same edge and cancels a pending count. The next entry into Operational waits the full delay again.
- R6: While the state is Suspend, a high `resume_det_i` moves the state to Resume on the next edge. In any other state, `resume_det_i` leaves the state unchanged.
- R7: When that hardware Suspend-to-Resume move coincides with a software write, the hardware move wins. The written state field is discarded, and the write's other fields still take effect.
- R8: `sw_reset_i` sets the state to Suspend and clears the remote-wakeup enable, the bulk-list enable, `bulk_proc_en_o` and `sof_en_o`. It keeps bits 9 and 8. It overrides a write or a resume in the same cycle.
- R9: `rwk_req_o` pulses high for exactly one cycle, one cycle after the remote-wakeup enable and `resume_det_i` first become true together. It stays low when the enable is clear. The enable has no effect on `irq_smi_o`.
- R10: `irq_smi_o` follows bit 8: 0 selects the normal host interrupt and 1 selects the system-management interrupt.
- R11: `bulk_proc_en_o` takes the value that bit 5 holds at a clock edge where `sof_pulse_i` is high. At all other edges it holds its value.
- R12: Bit 9 is plain read/write storage. Only hardware reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| sw_reset_i | input | 1 | Software reset strobe |
| wr_en_i | input | 1 | Register write enable |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data |
| resume_det_i | input | 1 | Resume signalling detected (status level) |
| sof_pulse_i | input | 1 | Frame boundary pulse |
| fstate_o | output | 2 | Current functional state |
| sof_en_o | output | 1 | Start-of-frame generation enable |
| rh_reset_o | output | 1 | Root-hub and downstream reset request |
| rwk_req_o | output | 1 | Remote-wakeup request pulse |
| irq_smi_o | output | 1 | Interrupt routed to system-management interrupt |
| bulk_proc_en_o | output | 1 | Bulk-list processing enable for the current frame |

## Verification
A wrong functional state shows on `rdata_o` and `fstate_o` on the edge after the bad transition. It also changes `rh_reset_o` in the same cycle, so the priority checks between resume, write and software reset catch it at once. A wrong millisecond counter shows only as `sof_en_o` rising one or more cycles off from the expected edge. The bench therefore samples `sof_en_o` on both sides of that edge, and again after an aborted count. A wrong bulk latch or wakeup-edge register shows as `bulk_proc_en_o` moving between frame pulses, or as `rwk_req_o` lasting a cycle too long, seen within one cycle.

// File: rtl/hc_ctrl_pkg.sv
package hc_ctrl_pkg;
  typedef enum logic [1:0] {
    FS_RESET  = 2'b00,
    FS_RESUME = 2'b01,
    FS_OPER   = 2'b10,
    FS_SUSP   = 2'b11
  } fstate_e;

  localparam int RWE_BIT = 10;
  localparam int RWC_BIT = 9;
  localparam int IR_BIT  = 8;
  localparam int FS_LSB  = 6;
  localparam int BLE_BIT = 5;
  localparam int USED_W  = 11;
endpackage

// File: rtl/hc_fstate_ctrl.sv
module hc_fstate_ctrl
  import hc_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sw_reset_i,
  input  logic       wr_en_i,
  input  logic [1:0] wr_fs_i,
  input  logic       resume_det_i,
  output fstate_e    fs_q_o,
  output fstate_e    fs_d_o,
  output logic       rh_reset_o
);
  fstate_e fs_q, fs_d;

  // priority: software reset, then hardware resume, then software write
  always_comb begin
    fs_d = fs_q;
    if (sw_reset_i)                            fs_d = FS_SUSP;
    else if (fs_q == FS_SUSP && resume_det_i)  fs_d = FS_RESUME;
    else if (wr_en_i)                          fs_d = fstate_e'(wr_fs_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fs_q <= FS_RESET;
    else         fs_q <= fs_d;
  end

  assign fs_q_o     = fs_q;
  assign fs_d_o     = fs_d;
  assign rh_reset_o = (fs_q == FS_RESET);
endmodule

// File: rtl/hc_sof_delay.sv
module hc_sof_delay #(
  parameter int CYC_PER_MS = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oper_now_i,
  input  logic oper_next_i,
  output logic sof_en_o
);
  localparam int CW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC_PER_MS - 1);

  logic [CW-1:0] cnt_q;
  logic          en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else if (!oper_next_i) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else if (!oper_now_i) begin
      cnt_q <= '0;  // entering operational
    end else if (!en_q) begin
      if (cnt_q == LAST) en_q  <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sof_en_o = en_q;
endmodule

// File: rtl/hc_bulk_latch.sv
module hc_bulk_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_reset_i,
  input  logic sof_pulse_i,
  input  logic ble_i,
  output logic bulk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          bulk_o <= 1'b0;
    else if (sw_reset_i)  bulk_o <= 1'b0;
    else if (sof_pulse_i) bulk_o <= ble_i;
  end
endmodule

// File: rtl/hc_rwk_pulse.sv
module hc_rwk_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  output logic pulse_o
);
  logic cond_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q  <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      cond_q  <= cond_i;
      pulse_o <= cond_i & ~cond_q;
    end
  end
endmodule

// File: rtl/hc_ctrl_reg.sv
module hc_ctrl_reg
  import hc_ctrl_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CYC_PER_MS = 50000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_reset_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              resume_det_i,
  input  logic              sof_pulse_i,
  output logic [1:0]        fstate_o,
  output logic              sof_en_o,
  output logic              rh_reset_o,
  output logic              rwk_req_o,
  output logic              irq_smi_o,
  output logic              bulk_proc_en_o
);
  localparam int PAD_W = DATA_W - USED_W;

  fstate_e fs_q, fs_d;
  logic    rwe_q, rwc_q, ir_q, ble_q;

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[DATA_W-1:USED_W], wdata_i[BLE_BIT-1:0]};

  hc_fstate_ctrl u_fstate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sw_reset_i   (sw_reset_i),
    .wr_en_i      (wr_en_i),
    .wr_fs_i      (wdata_i[FS_LSB+:2]),
    .resume_det_i (resume_det_i),
    .fs_q_o       (fs_q),
    .fs_d_o       (fs_d),
    .rh_reset_o   (rh_reset_o)
  );

  // control bits; software reset keeps the wakeup-connected and routing bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rwe_q <= 1'b0;
      rwc_q <= 1'b0;
      ir_q  <= 1'b0;
      ble_q <= 1'b0;
    end else if (sw_reset_i) begin
      rwe_q <= 1'b0;
      ble_q <= 1'b0;
    end else if (wr_en_i) begin
      rwe_q <= wdata_i[RWE_BIT];
      rwc_q <= wdata_i[RWC_BIT];
      ir_q  <= wdata_i[IR_BIT];
      ble_q <= wdata_i[BLE_BIT];
    end
  end

  hc_sof_delay #(.CYC_PER_MS(CYC_PER_MS)) u_sof (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .oper_now_i  (fs_q == FS_OPER),
    .oper_next_i (fs_d == FS_OPER),
    .sof_en_o    (sof_en_o)
  );

  hc_bulk_latch u_bulk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sw_reset_i  (sw_reset_i),
    .sof_pulse_i (sof_pulse_i),
    .ble_i       (ble_q),
    .bulk_o      (bulk_proc_en_o)
  );

  hc_rwk_pulse u_rwk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cond_i  (rwe_q & resume_det_i),
    .pulse_o (rwk_req_o)
  );

  assign rdata_o   = {{PAD_W{1'b0}}, rwe_q, rwc_q, ir_q, fs_q, ble_q, 5'b0};
  assign fstate_o  = fs_q;
  assign irq_smi_o = ir_q;
endmodule

// File: rtl/hc_ctrl_reg_chk.sv
module hc_ctrl_reg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sw_reset_i,
  input logic [31:0] rdata_o,
  input logic        resume_det_i,
  input logic        sof_pulse_i,
  input logic [1:0]  fstate_o,
  input logic        sof_en_o,
  input logic        rwk_req_o,
  input logic        bulk_proc_en_o
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[31:11] == '0 && rdata_o[4:0] == '0);

  // R4
  sof_only_oper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_en_o |-> fstate_o == 2'b10);

  // R6
  hw_resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fstate_o == 2'b11 && resume_det_i && !sw_reset_i) |=> fstate_o == 2'b01);

  // R8
  sw_reset_susp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_reset_i |=> (fstate_o == 2'b11 && !sof_en_o && !bulk_proc_en_o));

  // R9
  rwk_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rwk_req_o |=> !rwk_req_o);

  // R11
  bulk_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sof_pulse_i && !sw_reset_i) |=> $stable(bulk_proc_en_o));
endmodule

bind hc_ctrl_reg hc_ctrl_reg_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sw_reset_i     (sw_reset_i),
  .rdata_o        (rdata_o),
  .resume_det_i   (resume_det_i),
  .sof_pulse_i    (sof_pulse_i),
  .fstate_o       (fstate_o),
  .sof_en_o       (sof_en_o),
  .rwk_req_o      (rwk_req_o),
  .bulk_proc_en_o (bulk_proc_en_o)
);

// File: tb/hc_ctrl_reg_bench.sv
module hc_ctrl_reg_bench;
  localparam int CYC = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_reset = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        resume_det = 1'b0;
  logic        sof_pulse = 1'b0;
  logic [1:0]  fstate;
  logic        sof_en, rh_reset, rwk_req, irq_smi, bulk_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hc_ctrl_reg #(.CYC_PER_MS(CYC)) u_hc_ctrl_reg (
    .clk_i(clk), .rst_ni(rst_n), .sw_reset_i(sw_reset), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .resume_det_i(resume_det),
    .sof_pulse_i(sof_pulse), .fstate_o(fstate), .sof_en_o(sof_en),
    .rh_reset_o(rh_reset), .rwk_req_o(rwk_req), .irq_smi_o(irq_smi),
    .bulk_proc_en_o(bulk_en)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic write_reg(logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #3;
    check("R1 rdata in reset", rdata, 32'h0);
    check("R1 rh_reset in reset", {31'b0, rh_reset}, 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata after reset", rdata, 32'h0);
    check("R1 outputs after reset",
          {27'b0, sof_en, rwk_req, irq_smi, bulk_en, rh_reset}, 32'h1);
  endtask

  task automatic t_fields();
    write_reg(32'hFFFF_FFFF);
    check("R2 reserved zero, fields set", rdata, 32'h0000_07E0);
    check("R10 smi routing", {31'b0, irq_smi}, 32'h1);
    check("R12 rwc set", {31'b0, rdata[9]}, 32'h1);
    write_reg(32'h0000_0040);
    check("R2 state resume", rdata, 32'h0000_0040);
    check("R3 rh_reset low in resume", {31'b0, rh_reset}, 32'h0);
    check("R10 normal routing", {31'b0, irq_smi}, 32'h0);
    write_reg(32'h0000_0000);
    check("R3 rh_reset high in reset", {31'b0, rh_reset}, 32'h1);
  endtask

  task automatic t_sof_delay();
    write_reg(32'h0000_0080);
    repeat (CYC - 1) @(negedge clk);
    check("R4 sof low before delay", {31'b0, sof_en}, 32'h0);
    @(negedge clk);
    check("R4 sof high at delay", {31'b0, sof_en}, 32'h1);
    write_reg(32'h0000_0080);
    check("R4 rewrite keeps sof", {31'b0, sof_en}, 32'h1);
    write_reg(32'h0000_00C0);
    check("R5 sof dropped on leave", {31'b0, sof_en}, 32'h0);
    // aborted count
    write_reg(32'h0000_0080);
    repeat (CYC / 2) @(negedge clk);
    write_reg(32'h0000_0040);
    repeat (CYC + 5) @(negedge clk);
    check("R5 aborted count stays low", {31'b0, sof_en}, 32'h0);
    write_reg(32'h0000_0080);
    repeat (CYC - 1) @(negedge clk);
    check("R5 re-entry waits full delay", {31'b0, sof_en}, 32'h0);
    @(negedge clk);
    check("R5 re-entry sof high", {31'b0, sof_en}, 32'h1);
  endtask

  task automatic t_resume();
    // from operational: no effect
    @(negedge clk); resume_det = 1'b1;
    @(negedge clk);
    check("R6 no hw move from oper", {30'b0, fstate}, 32'h2);
    resume_det = 1'b0;
    write_reg(32'h0000_00C0);
    @(negedge clk); resume_det = 1'b1;
    @(negedge clk); resume_det = 1'b0;
    check("R6 suspend to resume", {30'b0, fstate}, 32'h1);
    // collision with software write
    write_reg(32'h0000_00C0);
    @(negedge clk);
    resume_det = 1'b1; wr_en = 1'b1; wdata = 32'h0000_0180;
    @(negedge clk);
    resume_det = 1'b0; wr_en = 1'b0; wdata = '0;
    check("R7 hw wins, other fields written", rdata, 32'h0000_0140);
  endtask

  task automatic t_bulk();
    write_reg(32'h0000_0020);
    repeat (3) @(negedge clk);
    check("R11 bulk waits for frame", {31'b0, bulk_en}, 32'h0);
    @(negedge clk); sof_pulse = 1'b1;
    @(negedge clk); sof_pulse = 1'b0;
    check("R11 bulk latched at frame", {31'b0, bulk_en}, 32'h1);
    write_reg(32'h0000_0000);
    repeat (2) @(negedge clk);
    check("R11 bulk held mid-frame", {31'b0, bulk_en}, 32'h1);
    @(negedge clk); sof_pulse = 1'b1;
    @(negedge clk); sof_pulse = 1'b0;
    check("R11 bulk cleared at frame", {31'b0, bulk_en}, 32'h0);
  endtask

  task automatic t_wakeup();
    write_reg(32'h0000_0080);
    @(negedge clk); resume_det = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 no pulse without enable", {31'b0, rwk_req}, 32'h0);
    resume_det = 1'b0;
    write_reg(32'h0000_0480);
    @(negedge clk); resume_det = 1'b1;
    @(negedge clk);
    check("R9 pulse high", {31'b0, rwk_req}, 32'h1);
    check("R9 routing unaffected", {31'b0, irq_smi}, 32'h0);
    @(negedge clk);
    check("R9 pulse one cycle", {31'b0, rwk_req}, 32'h0);
    resume_det = 1'b0;
  endtask

  task automatic t_sw_reset();
    write_reg(32'h0000_07A0);
    @(negedge clk); sof_pulse = 1'b1;
    @(negedge clk); sof_pulse = 1'b0;
    check("R8 setup bulk", {31'b0, bulk_en}, 32'h1);
    @(negedge clk);
    sw_reset = 1'b1; wr_en = 1'b1; wdata = 32'h0;
    @(negedge clk);
    sw_reset = 1'b0; wr_en = 1'b0;
    check("R8 sw reset keeps rwc and routing", rdata, 32'h0000_03C0);
    check("R8 sw reset clears outputs",
          {29'b0, sof_en, bulk_en, rh_reset}, 32'h0);
    check("R12 rwc survives sw reset", {31'b0, rdata[9]}, 32'h1);
    hw_reset();
    check("R12 rwc cleared by hw reset", {31'b0, rdata[9]}, 32'h0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    hw_reset();
    t_fields();
    t_sof_delay();
    t_resume();
    t_bulk();
    t_wakeup();
    t_sw_reset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule